// File: doc/BRIEF.md
# EDO DRAM Refresh and Power-Up Sequencer

This block owns the refresh duty of an EDO DRAM array. After reset it keeps the row and column strobes idle for a programmable power-up pause, then runs a fixed number of initialization refresh cycles in which the column strobe drops before the row strobe. Only then does it raise `ready`, which tells the host that normal accesses may begin.

In normal operation an interval timer marks one refresh as owed every `INTERVAL_CYC` clocks. Owed refreshes build up in a small saturating counter. The block asks the access controller for the strobes with `ref_req`, waits for `ref_ack`, and then drives the strobes itself, issuing every owed refresh back to back. A self-refresh request moves the array into self refresh with the same strobe ordering and holds it there. On exit the block waits a longer precharge, then runs a catch-up burst of refresh cycles with `ready` low before it returns to normal operation.

Top module: `edo_refresh_seq`

## Requirements
- R1: For `PWRUP_CYC` clocks after reset, `ras_n` and `cas_n` stay high, `ref_req` stays low and `ready` stays low.
- R2: After the pause, exactly `INIT_CNT` refresh cycles are issued, and `ready` rises on the clock after the precharge of the last one ends.
- R3: In every refresh cycle `cas_n` falls exactly `LEAD_CYC` clocks before `ras_n` falls, stays low while `ras_n` is low, and rises in the same clock as `ras_n`.
- R4: In a normal refresh `ras_n` is low for exactly `RAS_LOW_CYC` clocks, and it then stays high at least `PRECH_CYC` clocks before `cas_n` falls again.
- R5: A refresh cycle starts only when `ref_ack` is high. While a refresh is owed and `ref_ack` is low, `ref_req` stays high and no strobe moves.
- R6: While `ready` is high, one refresh becomes owed every `INTERVAL_CYC` clocks, counted from the rise of `ready`. Refreshes owed while `ref_ack` was withheld are all issued back to back once it is granted.
- R7: The number of owed refreshes saturates at 2^`PEND_W`-1. Further intervals that pass while ack is withheld are dropped.
- R8: When `self_req` is high while `ready` is high, the block enters self refresh with the R3 ordering. It keeps `ras_n` low while `self_req` stays high and for at least `SR_MIN_CYC` clocks in total, even if `self_req` drops earlier.
- R9: After self refresh, `ras_n` stays high at least `SR_PRE_CYC` clocks before the next `cas_n` fall.
- R10: After self refresh, exactly `BURST_CNT` normal refresh cycles are issued. `ready` is low from self-refresh entry until the clock after the last burst precharge ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ack | input | 1 | Access controller grants the strobes to this block |
| self_req | input | 1 | Level request to enter and stay in self refresh |
| ref_req | output | 1 | Request for ownership of the strobes |
| ready | output | 1 | High when host accesses may proceed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |

## Verification
The assertions assume that `ref_ack` is driven away from the active edge and is never high unless `ref_req` was high. They also assume that `self_req` is raised only while `ready` is high and no refresh burst is pending near an interval boundary. The stimulus keeps to this as follows. A bench arbiter derives `ref_ack` from `ref_req` on the falling edge. Every phase change is timed half an interval away from a timer expiry, so the number of owed refreshes in each window is known exactly. `self_req` is raised only after the previous drain has finished.

// File: rtl/edo_rfsh_pkg.sv
package edo_rfsh_pkg;

  typedef enum logic [2:0] {
    MODE_PWRUP,
    MODE_INIT,
    MODE_RUN,
    MODE_SELF,
    MODE_BURST
  } rf_mode_e;

  typedef enum logic [1:0] {
    STB_IDLE,
    STB_LEAD,
    STB_LOW,
    STB_PRE
  } stb_state_e;

  // bits needed to hold values 0..n
  function automatic int unsigned bits_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_rfsh_strobe.sv
module edo_rfsh_strobe
  import edo_rfsh_pkg::*;
#(
  parameter int unsigned LEAD_CYC    = 2,
  parameter int unsigned RAS_LOW_CYC = 13,
  parameter int unsigned PRECH_CYC   = 8,
  parameter int unsigned SR_MIN_CYC  = 25000,
  parameter int unsigned SR_PRE_CYC  = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_self,
  input  logic self_hold,
  output logic ras_n,
  output logic cas_n,
  output logic busy,
  output logic done
);

  localparam int unsigned CW = bits_for(max2(max2(max2(LEAD_CYC, RAS_LOW_CYC),
                                                  max2(PRECH_CYC, SR_PRE_CYC)), SR_MIN_CYC));
  localparam logic [CW-1:0] LEAD_LAST  = CW'(LEAD_CYC - 1);
  localparam logic [CW-1:0] LOW_LAST   = CW'(RAS_LOW_CYC - 1);
  localparam logic [CW-1:0] PRE_LAST   = CW'(PRECH_CYC - 1);
  localparam logic [CW-1:0] SRMIN_LAST = CW'(SR_MIN_CYC - 1);
  localparam logic [CW-1:0] SRPRE_LAST = CW'(SR_PRE_CYC - 1);

  stb_state_e    st;
  logic [CW-1:0] cnt;
  logic          self_q;
  logic          lead_last;
  logic          low_last;
  logic          pre_last;
  logic          self_min_met;

  always_comb begin
    self_min_met = (cnt >= SRMIN_LAST);
    lead_last    = (cnt == LEAD_LAST);
    low_last     = self_q ? (self_min_met && !self_hold) : (cnt == LOW_LAST);
    pre_last     = (cnt == (self_q ? SRPRE_LAST : PRE_LAST));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= STB_IDLE;
      cnt    <= '0;
      self_q <= 1'b0;
    end else begin
      case (st)
        STB_IDLE: begin
          if (start) begin
            st     <= STB_LEAD;
            cnt    <= '0;
            self_q <= start_self;
          end
        end
        STB_LEAD: begin
          if (lead_last) begin
            st  <= STB_LOW;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        STB_LOW: begin
          if (low_last) begin
            st  <= STB_PRE;
            cnt <= '0;
          end else if (!(self_q && self_min_met)) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (pre_last) begin
            st  <= STB_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign ras_n = (st != STB_LOW);
  assign cas_n = !((st == STB_LEAD) || (st == STB_LOW));
  assign busy  = (st != STB_IDLE);
  assign done  = (st == STB_PRE) && pre_last;

  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n)); // R3
  AST_CAS_RELEASE_WITH_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> $rose(ras_n)); // R3
  AST_PRECHARGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> (ras_n && cas_n)); // R4
  AST_SELF_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && self_q) |-> ($past(cnt) >= SRMIN_LAST)); // R8

endmodule

// File: rtl/edo_rfsh_interval.sv
module edo_rfsh_interval
  import edo_rfsh_pkg::*;
#(
  parameter int unsigned INTERVAL_CYC = 3900,
  parameter int unsigned PEND_W       = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic consume,
  output logic pend_nz
);

  localparam int unsigned TW = bits_for(INTERVAL_CYC);
  localparam logic [TW-1:0]     TICK_LAST = TW'(INTERVAL_CYC - 1);
  localparam logic [PEND_W-1:0] PEND_MAX  = '1;

  logic [TW-1:0]     tcnt;
  logic [PEND_W-1:0] pend;
  logic              tick;

  // saturating up/down step of the owed-refresh count
  function automatic logic [PEND_W-1:0] pend_step(input logic [PEND_W-1:0] cur,
                                                  input logic inc, input logic dec);
    if (inc && !dec) return (cur == PEND_MAX) ? cur : cur + 1'b1;
    if (dec && !inc) return (cur == '0) ? cur : cur - 1'b1;
    return cur;
  endfunction

  assign tick = enable && (tcnt == TICK_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      tcnt <= '0;
      pend <= '0;
    end else begin
      tcnt <= tick ? '0 : tcnt + 1'b1;
      pend <= pend_step(pend, tick, consume);
    end
  end

  assign pend_nz = (pend != '0);

  AST_PEND_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && pend == PEND_MAX && !consume) |=> (pend == PEND_MAX)); // R7
  AST_PEND_COUNTS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && !consume && pend != PEND_MAX) |=> (pend == $past(pend) + 1'b1)); // R6

endmodule

// File: rtl/edo_rfsh_ctrl.sv
module edo_rfsh_ctrl
  import edo_rfsh_pkg::*;
#(
  parameter int unsigned PWRUP_CYC = 50000000,
  parameter int unsigned INIT_CNT  = 8,
  parameter int unsigned BURST_CNT = 4096
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ref_ack,
  input  logic     self_req,
  input  logic     pend_nz,
  input  logic     eng_busy,
  input  logic     eng_done,
  output logic     eng_start,
  output logic     eng_start_self,
  output logic     consume,
  output logic     run_en,
  output logic     ref_req,
  output logic     ready,
  output rf_mode_e mode
);

  localparam int unsigned PW = bits_for(PWRUP_CYC);
  localparam int unsigned SW = bits_for(max2(INIT_CNT, BURST_CNT));
  localparam logic [PW-1:0] PWRUP_LAST = PW'(PWRUP_CYC - 1);
  localparam logic [SW-1:0] INIT_LAST  = SW'(INIT_CNT - 1);
  localparam logic [SW-1:0] BURST_LAST = SW'(BURST_CNT - 1);

  logic [PW-1:0] pu_cnt;
  logic [SW-1:0] seq_cnt;
  logic          seq_last;
  logic          want_norm;
  logic          want_self;
  logic          grant;
  logic          owns_strobes;

  always_comb begin
    seq_last     = (seq_cnt == ((mode == MODE_INIT) ? INIT_LAST : BURST_LAST));
    owns_strobes = (mode == MODE_INIT) || (mode == MODE_SELF) || (mode == MODE_BURST);
    want_self    = (mode == MODE_RUN) && self_req;
    want_norm    = (mode == MODE_INIT) || (mode == MODE_BURST) ||
                   ((mode == MODE_RUN) && pend_nz && !self_req);
    grant        = ref_ack && !eng_busy;
    eng_start      = grant && (want_norm || want_self);
    eng_start_self = grant && want_self;
    consume        = grant && want_norm && (mode == MODE_RUN);
    ref_req        = owns_strobes || eng_busy || want_norm || want_self;
    run_en         = (mode == MODE_RUN);
    ready          = (mode == MODE_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= MODE_PWRUP;
      pu_cnt  <= '0;
      seq_cnt <= '0;
    end else begin
      case (mode)
        MODE_PWRUP: begin
          if (pu_cnt == PWRUP_LAST) mode <= MODE_INIT;
          else                      pu_cnt <= pu_cnt + 1'b1;
        end
        MODE_INIT, MODE_BURST: begin
          if (eng_done) begin
            if (seq_last) begin
              mode    <= MODE_RUN;
              seq_cnt <= '0;
            end else begin
              seq_cnt <= seq_cnt + 1'b1;
            end
          end
        end
        MODE_RUN: begin
          if (eng_start_self) mode <= MODE_SELF;
        end
        default: begin
          if (eng_done) begin
            mode    <= MODE_BURST;
            seq_cnt <= '0;
          end
        end
      endcase
    end
  end

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(eng_done)); // R2
  AST_SELF_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_self |=> !ready); // R10

endmodule

// File: rtl/edo_refresh_seq.sv
module edo_refresh_seq
  import edo_rfsh_pkg::*;
#(
  parameter int unsigned PWRUP_CYC    = 50000000,
  parameter int unsigned INIT_CNT     = 8,
  parameter int unsigned INTERVAL_CYC = 3900,
  parameter int unsigned PEND_W       = 3,
  parameter int unsigned LEAD_CYC     = 2,
  parameter int unsigned RAS_LOW_CYC  = 13,
  parameter int unsigned PRECH_CYC    = 8,
  parameter int unsigned SR_MIN_CYC   = 25000,
  parameter int unsigned SR_PRE_CYC   = 28,
  parameter int unsigned BURST_CNT    = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  input  logic self_req,
  output logic ref_req,
  output logic ready,
  output logic ras_n,
  output logic cas_n
);

  logic     eng_start;
  logic     eng_start_self;
  logic     eng_busy;
  logic     eng_done;
  logic     consume;
  logic     run_en;
  logic     pend_nz;
  rf_mode_e mode;

  edo_rfsh_ctrl #(
    .PWRUP_CYC (PWRUP_CYC),
    .INIT_CNT  (INIT_CNT),
    .BURST_CNT (BURST_CNT)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .ref_ack        (ref_ack),
    .self_req       (self_req),
    .pend_nz        (pend_nz),
    .eng_busy       (eng_busy),
    .eng_done       (eng_done),
    .eng_start      (eng_start),
    .eng_start_self (eng_start_self),
    .consume        (consume),
    .run_en         (run_en),
    .ref_req        (ref_req),
    .ready          (ready),
    .mode           (mode)
  );

  edo_rfsh_interval #(
    .INTERVAL_CYC (INTERVAL_CYC),
    .PEND_W       (PEND_W)
  ) u_interval (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (run_en),
    .consume (consume),
    .pend_nz (pend_nz)
  );

  edo_rfsh_strobe #(
    .LEAD_CYC    (LEAD_CYC),
    .RAS_LOW_CYC (RAS_LOW_CYC),
    .PRECH_CYC   (PRECH_CYC),
    .SR_MIN_CYC  (SR_MIN_CYC),
    .SR_PRE_CYC  (SR_PRE_CYC)
  ) u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (eng_start),
    .start_self (eng_start_self),
    .self_hold  (self_req),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .busy       (eng_busy),
    .done       (eng_done)
  );

  AST_PWRUP_LINES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PWRUP) |-> (ras_n && cas_n && !ref_req)); // R1
  AST_STROBE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(ref_ack)); // R5

endmodule

// File: tb/tb_edo_refresh_seq.sv
module tb_edo_refresh_seq;

  localparam int PWRUP  = 300;
  localparam int INITN  = 8;
  localparam int INTV   = 600;
  localparam int PENDW  = 3;
  localparam int LEAD   = 2;
  localparam int LOWC   = 13;
  localparam int PREC   = 8;
  localparam int SRMIN  = 60;
  localparam int SRPRE  = 28;
  localparam int BURST  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_ack = 1'b0;
  logic self_req = 1'b0;
  logic ref_req, ready, ras_n, cas_n;

  edo_refresh_seq #(
    .PWRUP_CYC(PWRUP), .INIT_CNT(INITN), .INTERVAL_CYC(INTV), .PEND_W(PENDW),
    .LEAD_CYC(LEAD), .RAS_LOW_CYC(LOWC), .PRECH_CYC(PREC),
    .SR_MIN_CYC(SRMIN), .SR_PRE_CYC(SRPRE), .BURST_CNT(BURST)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .self_req(self_req),
    .ref_req(ref_req), .ready(ready), .ras_n(ras_n), .cas_n(cas_n)
  );

  always #2 clk = ~clk;

  int  cyc = 0;
  int  n_chk = 0;
  int  n_fail = 0;
  bit  ack_en = 1'b0;
  bit  exp_q[$];
  int  n_norm = 0, n_self = 0, cas_falls = 0;
  int  lead = 0, low = 0, rise_cyc = 0, last_self_low = 0;
  bit  have_rise = 1'b0, last_self = 1'b0;
  bit  prev_ras = 1'b1, prev_cas = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // arbiter: grant follows request when enabled
  always @(negedge clk) ref_ack <= rst_n && ref_req && ack_en;

  // monitor: measures each strobe cycle and compares with the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cas_n && prev_cas) begin
        cas_falls++;
        lead = 0;
        low  = 0;
        if (have_rise) begin
          if (last_self) chk(cyc - rise_cyc >= SRPRE, "R9", "precharge after self refresh", cyc - rise_cyc, SRPRE);
          else           chk(cyc - rise_cyc >= PREC,  "R4", "precharge before next cycle", cyc - rise_cyc, PREC);
        end
      end
      if (!cas_n && ras_n) lead++;
      if (!ras_n) low++;
      if (cas_n && !prev_cas && prev_ras)
        chk(1'b0, "R3", "cas released while ras high", 1, 0);
      if (ras_n && !prev_ras) begin
        chk(cas_n, "R3", "cas released with ras", int'(cas_n), 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected refresh cycle", 1, 0);
        end else begin
          bit is_self;
          is_self = exp_q.pop_front();
          chk(lead == LEAD, "R3", "cas lead before ras", lead, LEAD);
          if (is_self) begin
            chk(low >= SRMIN, "R8", "self refresh ras low width", low, SRMIN);
            last_self_low = low;
            n_self++;
          end else begin
            chk(low == LOWC, "R4", "normal ras low width", low, LOWC);
            n_norm++;
          end
          last_self = is_self;
        end
        rise_cyc  = cyc;
        have_rise = 1'b1;
      end
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  task automatic push_items(input int n, input bit is_self);
    for (int i = 0; i < n; i++) exp_q.push_back(is_self);
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wait_ready(input int limit, input string req);
    int k;
    k = 0;
    while (!ready && k < limit) begin
      @(negedge clk);
      k++;
    end
    chk(ready, req, "ready reached", int'(ready), 1);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    int t0, n0, f0, g, ready_at;
    push_items(INITN, 1'b0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ready == 1'b0, "R1", "ready after reset", int'(ready), 0);
    chk(ras_n && cas_n, "R1", "strobes idle after reset", int'({ras_n, cas_n}), 3);
    chk(ref_req == 1'b0, "R1", "no request after reset", int'(ref_req), 0);
    ack_en = 1'b1;
    repeat (PWRUP - 20) @(negedge clk);
    chk(ref_req == 1'b0, "R1", "no request during pause", int'(ref_req), 0);
    chk(cas_falls == 0, "R1", "no strobe during pause", cas_falls, 0);

    // R2 initialization
    wait_ready(2000, "R2");
    ready_at = cyc;
    chk(n_norm == INITN, "R2", "init cycles before ready", n_norm, INITN);
    chk(ready_at - rise_cyc == PREC, "R2", "ready after last precharge", ready_at - rise_cyc, PREC);
    t0 = cyc;

    // R6 periodic refresh with immediate grant
    n0 = n_norm;
    push_items(3, 1'b0);
    wait_to(t0 + 3 * INTV + INTV / 2);
    chk(n_norm - n0 == 3, "R6", "one refresh per interval", n_norm - n0, 3);

    // R5 withheld grant, then R6 back-to-back drain
    ack_en = 1'b0;
    f0 = cas_falls;
    wait_to(t0 + 7 * INTV + INTV / 2);
    chk(ref_req == 1'b1, "R5", "request held while owed", int'(ref_req), 1);
    chk(cas_falls == f0, "R5", "no strobe without grant", cas_falls - f0, 0);
    n0 = n_norm;
    push_items(4, 1'b0);
    g = cyc;
    ack_en = 1'b1;
    wait_to(t0 + 7 * INTV + 3 * INTV / 4);
    chk(n_norm - n0 == 4, "R6", "accumulated refreshes issued", n_norm - n0, 4);
    chk(rise_cyc - g <= 4 * (LEAD + LOWC + PREC + 3) + 3, "R6", "drain back to back",
        rise_cyc - g, 4 * (LEAD + LOWC + PREC + 3) + 3);
    chk(ready == 1'b1, "R6", "ready stays high in run", int'(ready), 1);

    // R7 saturation of owed count
    ack_en = 1'b0;
    wait_to(t0 + 17 * INTV + INTV / 2);
    n0 = n_norm;
    push_items((1 << PENDW) - 1, 1'b0);
    ack_en = 1'b1;
    wait_to(t0 + 17 * INTV + INTV / 2 + 270);
    chk(n_norm - n0 == (1 << PENDW) - 1, "R7", "saturated owed count", n_norm - n0, (1 << PENDW) - 1);

    // R8 / R9 / R10 long self refresh
    n0 = n_norm;
    push_items(1, 1'b1);
    push_items(BURST, 1'b0);
    self_req = 1'b1;
    repeat (50) @(negedge clk);
    chk(ready == 1'b0, "R10", "ready low in self refresh", int'(ready), 0);
    repeat (50) @(negedge clk);
    self_req = 1'b0;
    repeat (SRPRE + 10) @(negedge clk);
    chk(ready == 1'b0, "R10", "ready low during burst", int'(ready), 0);
    wait_ready(5000, "R10");
    ready_at = cyc;
    chk(n_self == 1, "R8", "self refresh entered", n_self, 1);
    chk(last_self_low >= 100 - LEAD - 3, "R8", "ras held while requested", last_self_low, 100 - LEAD - 3);
    chk(n_norm - n0 == BURST, "R10", "burst length", n_norm - n0, BURST);
    chk(ready_at - rise_cyc == PREC, "R10", "ready after burst precharge", ready_at - rise_cyc, PREC);

    // R8 short request still gets the minimum low time
    n0 = n_norm;
    push_items(1, 1'b1);
    push_items(BURST, 1'b0);
    self_req = 1'b1;
    repeat (10) @(negedge clk);
    self_req = 1'b0;
    wait_ready(5000, "R10");
    chk(n_self == 2, "R8", "second self refresh entered", n_self, 2);
    chk(last_self_low == SRMIN, "R8", "minimum self refresh width", last_self_low, SRMIN);
    chk(n_norm - n0 == BURST, "R10", "second burst length", n_norm - n0, BURST);
    chk(exp_q.size() == 0, "R5", "all expected cycles seen", exp_q.size(), 0);
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule